// File: doc/BRIEF.md
# Performance Counter Bank with Overflow Flags

This block holds a set of 32-bit event counters and one free-running cycle counter, all controlled through a small word-addressed register port. Each event counter advances on its own input strobe. The cycle counter advances on every clock. Both kinds only count while the global enable and the counter's own enable bit are set. When a counter rolls over from all ones it raises a sticky overflow flag. A level interrupt is asserted while any raised flag also has its interrupt enable set.

Software sets and clears enable and interrupt-enable bits through separate one-hot registers, so it never needs a read-modify-write. It clears overflow flags by writing ones. Event counters and their 8-bit event-type registers are reached through a select register followed by a data access. The cycle counter has its own data address. In every mask register the cycle counter sits at bit 31 and event counter k sits at bit k.

Top module: `perfbank`

## Requirements
- R1: After reset all counters, masks, flags, the select register and the event-type registers are zero, `irq` is low, and the control register at offset 0x0 reads `NUM_EVT << 11`.
- R2: A write to the control register (0x0) keeps only wdata[7:0], and bit 0 is the global enable. Bits 15:11 always read back NUM_EVT, whatever is written, and bits 10:8 read zero.
- R3: Writing ones to enable-set (0x1) or enable-clear (0x2) sets or clears only those mask bits, and the same holds for interrupt-enable-set (0x3) and interrupt-enable-clear (0x4). Event counter k uses bit k and the cycle counter uses bit 31. Bits of counters that do not exist read zero. Reading either address of a pair returns that mask.
- R4: Event counter k grows by one on each clock where evt_strobe[k], the global enable and enable bit k are all high. Otherwise it holds.
- R5: The cycle counter grows by one on each clock where the global enable and enable bit 31 are both high. Otherwise it holds.
- R6: The select register (0x6) picks an event counter. Reads and writes at 0x7 then reach that counter's value, and at 0x8 its event type, which keeps wdata[7:0]. Other counters are untouched.
- R7: The cycle counter is read and written directly at offset 0x9, independent of the select register.
- R8: A counter that increments from 0xFFFFFFFF becomes 0 and sets its overflow flag in the same clock.
- R9: The overflow register (0x5) reads the flags. Writing a 1 clears that flag, and writing a 0 leaves it unchanged. A wrap in the same clock as a clearing write leaves the flag set.
- R10: `irq` is high exactly while some overflow flag is set together with its interrupt-enable bit.
- R11: A write to a counter's data register in the same clock as an increment loads the written value, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word offset |
| wdata | input | 32 | Write data |
| evt_strobe | input | NUM_EVT | Per-counter event increment strobes |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level overflow interrupt |

## Verification
Strobe patterns mix all counters strobing, a single counter strobing, and strobes with the global enable off. Together they separate the per-counter enable gate from the global gate. Counters preloaded just below all ones show the wrap and its flag on both the event and the cycle paths. Writes that collide with increments or wraps in one clock show the load priority and the flag-set priority. Interrupt-enable patterns that do and do not match a raised flag show that the interrupt depends on the pairing, not on either mask alone.

// File: rtl/perfbank_pkg.sv
package perfbank_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int CYC_BIT    = 31;
    localparam int CTRL_KEEP  = 8;
    localparam int EVTYPE_W   = 8;
    localparam int NUM_FLD_LO = 11;
    localparam int NUM_FLD_W  = 5;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 4'h0,
        REG_EN_SET  = 4'h1,
        REG_EN_CLR  = 4'h2,
        REG_IE_SET  = 4'h3,
        REG_IE_CLR  = 4'h4,
        REG_OVF     = 4'h5,
        REG_SEL     = 4'h6,
        REG_EVDATA  = 4'h7,
        REG_EVTYPE  = 4'h8,
        REG_CYCDATA = 4'h9
    } reg_addr_e;

endpackage

// File: rtl/perfbank_counter.sv
module perfbank_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] value,
    output logic             wrap
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_st_t;

    cnt_st_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d.cnt = load_val;
        end else if (inc) begin
            cnt_d.cnt = cnt_q.cnt + WIDTH'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value = cnt_q.cnt;
    // roll-over happens only on a real increment, never on a load
    assign wrap  = inc && !load && (&cnt_q.cnt);

endmodule

// File: rtl/perfbank_rdmux.sv
module perfbank_rdmux
    import perfbank_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int SEL_W   = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CTRL_KEEP-1:0] ctrl,
    input  logic [DATA_W-1:0]    en_mask,
    input  logic [DATA_W-1:0]    ie_mask,
    input  logic [DATA_W-1:0]    ovf_mask,
    input  logic [SEL_W-1:0]     sel,
    input  logic [DATA_W-1:0]    evt_sel_val,
    input  logic [EVTYPE_W-1:0]  evtype_sel,
    input  logic [DATA_W-1:0]    cyc_val,
    output logic [DATA_W-1:0]    rdata
);

    localparam logic [NUM_FLD_W-1:0] NUM_FLD = NUM_FLD_W'(NUM_EVT);

    always_comb begin
        rdata = '0;
        case (addr)
            REG_CTRL: begin
                rdata[CTRL_KEEP-1:0]                     = ctrl;
                rdata[NUM_FLD_LO+NUM_FLD_W-1:NUM_FLD_LO] = NUM_FLD;
            end
            REG_EN_SET, REG_EN_CLR: rdata = en_mask;
            REG_IE_SET, REG_IE_CLR: rdata = ie_mask;
            REG_OVF:                rdata = ovf_mask;
            REG_SEL:                rdata = DATA_W'(sel);
            REG_EVDATA:             rdata = evt_sel_val;
            REG_EVTYPE:             rdata = DATA_W'(evtype_sel);
            REG_CYCDATA:            rdata = cyc_val;
            default:                rdata = '0;
        endcase
    end

endmodule

// File: rtl/perfbank.sv
module perfbank
    import perfbank_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq
);

    localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
    localparam logic [DATA_W-1:0] EVT_BITS   = (DATA_W'(1) << NUM_EVT) - DATA_W'(1);
    localparam logic [DATA_W-1:0] VALID_MASK = EVT_BITS | (DATA_W'(1) << CYC_BIT);

    typedef struct packed {
        logic [CTRL_KEEP-1:0]                ctrl;
        logic [DATA_W-1:0]                   en;
        logic [DATA_W-1:0]                   ie;
        logic [DATA_W-1:0]                   ovf;
        logic [SEL_W-1:0]                    sel;
        logic [NUM_EVT-1:0][EVTYPE_W-1:0]    evtype;
    } bank_st_t;

    bank_st_t st_d, st_q;

    // decoded writes
    logic wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr;
    logic wr_ovf, wr_sel, wr_evdata, wr_evtype, wr_cyc;
    assign wr_ctrl   = wr_en && (addr == REG_CTRL);
    assign wr_en_set = wr_en && (addr == REG_EN_SET);
    assign wr_en_clr = wr_en && (addr == REG_EN_CLR);
    assign wr_ie_set = wr_en && (addr == REG_IE_SET);
    assign wr_ie_clr = wr_en && (addr == REG_IE_CLR);
    assign wr_ovf    = wr_en && (addr == REG_OVF);
    assign wr_sel    = wr_en && (addr == REG_SEL);
    assign wr_evdata = wr_en && (addr == REG_EVDATA);
    assign wr_evtype = wr_en && (addr == REG_EVTYPE);
    assign wr_cyc    = wr_en && (addr == REG_CYCDATA);

    logic              glob_en;
    logic [DATA_W-1:0] en_mask, ie_mask, ovf_mask;
    logic              sel_ok;
    assign glob_en  = st_q.ctrl[0];
    assign en_mask  = st_q.en;
    assign ie_mask  = st_q.ie;
    assign ovf_mask = st_q.ovf;
    assign sel_ok   = (32'(st_q.sel) < NUM_EVT);

    // counter datapaths
    logic [NUM_EVT-1:0]             evt_inc, evt_load, evt_wrap;
    logic [NUM_EVT-1:0][DATA_W-1:0] evt_val;
    logic                           cyc_inc, cyc_wrap;
    logic [DATA_W-1:0]              cyc_val;

    for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
        assign evt_inc[k]  = glob_en && en_mask[k] && evt_strobe[k];
        assign evt_load[k] = wr_evdata && sel_ok && (st_q.sel == SEL_W'(k));
        perfbank_counter #(.WIDTH(DATA_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc      (evt_inc[k]),
            .load     (evt_load[k]),
            .load_val (wdata),
            .value    (evt_val[k]),
            .wrap     (evt_wrap[k])
        );
    end

    assign cyc_inc = glob_en && en_mask[CYC_BIT];

    perfbank_counter #(.WIDTH(DATA_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cyc_inc),
        .load     (wr_cyc),
        .load_val (wdata),
        .value    (cyc_val),
        .wrap     (cyc_wrap)
    );

    logic [DATA_W-1:0] wrap_vec;
    always_comb begin
        wrap_vec                 = '0;
        wrap_vec[NUM_EVT-1:0]    = evt_wrap;
        wrap_vec[CYC_BIT]        = cyc_wrap;
    end

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (wr_ctrl)   st_d.ctrl = wdata[CTRL_KEEP-1:0];
        if (wr_en_set) st_d.en   = st_q.en | (wdata & VALID_MASK);
        if (wr_en_clr) st_d.en   = st_q.en & ~wdata;
        if (wr_ie_set) st_d.ie   = st_q.ie | (wdata & VALID_MASK);
        if (wr_ie_clr) st_d.ie   = st_q.ie & ~wdata;
        if (wr_sel)    st_d.sel  = wdata[SEL_W-1:0];
        if (wr_evtype && sel_ok) st_d.evtype[st_q.sel] = wdata[EVTYPE_W-1:0];
        // a fresh wrap beats a clearing write in the same clock
        st_d.ovf = (st_q.ovf & ~(wr_ovf ? wdata : '0)) | wrap_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = |(ovf_mask & ie_mask);

    logic [DATA_W-1:0]   evt_sel_val;
    logic [EVTYPE_W-1:0] evtype_sel;
    assign evt_sel_val = sel_ok ? evt_val[st_q.sel] : '0;
    assign evtype_sel  = sel_ok ? st_q.evtype[st_q.sel] : '0;

    perfbank_rdmux #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_rdmux (
        .addr        (addr),
        .ctrl        (st_q.ctrl),
        .en_mask     (en_mask),
        .ie_mask     (ie_mask),
        .ovf_mask    (ovf_mask),
        .sel         (st_q.sel),
        .evt_sel_val (evt_sel_val),
        .evtype_sel  (evtype_sel),
        .cyc_val     (cyc_val),
        .rdata       (rdata)
    );

endmodule

// File: rtl/perfbank_chk.sv
module perfbank_chk
    import perfbank_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic              glob_en,
    input logic [DATA_W-1:0] en_mask,
    input logic [DATA_W-1:0] ovf_mask,
    input logic [DATA_W-1:0] cyc_val
);

    logic cyc_wr, ovf_wr;
    assign cyc_wr = wr_en && (addr == REG_CYCDATA);
    assign ovf_wr = wr_en && (addr == REG_OVF);

    assert_ctrl_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_CTRL) |-> (rdata[NUM_FLD_LO+NUM_FLD_W-1:NUM_FLD_LO] == NUM_FLD_W'(NUM_EVT)));

    assert_cyc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && en_mask[CYC_BIT] && !cyc_wr) |=> (cyc_val == $past(cyc_val) + DATA_W'(1)));

    assert_cyc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !cyc_wr) |=> $stable(cyc_val));

    assert_cyc_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && en_mask[CYC_BIT] && !cyc_wr && (&cyc_val)) |=> ovf_mask[CYC_BIT]);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_wr |=> ((ovf_mask & $past(ovf_mask)) == $past(ovf_mask)));

    assert_irq_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_mask != '0));

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_wr |=> (cyc_val == $past(wdata)));

endmodule

bind perfbank perfbank_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .irq      (irq),
    .glob_en  (glob_en),
    .en_mask  (en_mask),
    .ovf_mask (ovf_mask),
    .cyc_val  (cyc_val)
);

// File: tb/perfbank_tb.sv
module perfbank_tb;
    import perfbank_pkg::*;

    localparam int NUM_EVT = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic [NUM_EVT-1:0] evt_strobe = '0;
    logic [DATA_W-1:0]  rdata;
    logic               irq;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    perfbank #(.NUM_EVT(NUM_EVT)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .evt_strobe (evt_strobe),
        .rdata      (rdata),
        .irq        (irq)
    );

    typedef struct {
        bit                is_irq;
        logic [DATA_W-1:0] exp;
        string             tag;
    } item_t;

    item_t sb_q[$];

    // monitor: compares expected items once the outputs have settled
    always begin
        @(negedge clk);
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [DATA_W-1:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? DATA_W'(irq) : rdata;
            n_total++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
            end
        end
    end

    // driver tasks: start and end at a falling edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string t);
        item_t it;
        addr      = a;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.tag    = t;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic irq_chk(input logic e, input string t);
        item_t it;
        it.is_irq = 1'b1;
        it.exp    = DATA_W'(e);
        it.tag    = t;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic pulse(input logic [NUM_EVT-1:0] p, input int n);
        evt_strobe = p;
        repeat (n) @(negedge clk);
        evt_strobe = '0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(REG_CTRL,    32'h0000_2000, "R1 ctrl after reset");
        rd_chk(REG_EN_SET,  32'h0,         "R1 enable mask after reset");
        rd_chk(REG_OVF,     32'h0,         "R1 overflow after reset");
        rd_chk(REG_CYCDATA, 32'h0,         "R1 cycle counter after reset");
        irq_chk(1'b0,                      "R1 irq after reset");

        // R2 control register
        wr(REG_CTRL, 32'hFFFF_FFFF);
        rd_chk(REG_CTRL, 32'h0000_20FF, "R2 low byte kept");
        wr(REG_CTRL, 32'h0000_F800);
        rd_chk(REG_CTRL, 32'h0000_2000, "R2 count field read-only");

        // R3 set/clear masks
        wr(REG_EN_SET, 32'hFFFF_FFFF);
        rd_chk(REG_EN_SET, 32'h8000_000F, "R3 enable set all");
        wr(REG_EN_CLR, 32'h0000_0005);
        rd_chk(REG_EN_CLR, 32'h8000_000A, "R3 enable clear bits 0,2");
        wr(REG_EN_CLR, 32'hFFFF_FFFF);
        rd_chk(REG_EN_SET, 32'h0, "R3 enable clear all");
        wr(REG_IE_SET, 32'h8000_0002);
        rd_chk(REG_IE_SET, 32'h8000_0002, "R3 irq-enable set");
        wr(REG_IE_CLR, 32'h8000_0000);
        rd_chk(REG_IE_CLR, 32'h0000_0002, "R3 irq-enable clear bit 31");
        wr(REG_IE_CLR, 32'h0000_0002);
        rd_chk(REG_IE_SET, 32'h0, "R3 irq-enable clear bit 1");

        // R6 indirect access
        for (int k = 0; k < NUM_EVT; k++) begin
            wr(REG_SEL, 32'(k));
            wr(REG_EVDATA, 32'h10 + 32'(k));
        end
        for (int k = 0; k < NUM_EVT; k++) begin
            wr(REG_SEL, 32'(k));
            rd_chk(REG_EVDATA, 32'h10 + 32'(k), "R6 selected counter data");
        end
        wr(REG_SEL, 32'd1);
        wr(REG_EVTYPE, 32'h0000_01A5);
        wr(REG_SEL, 32'd2);
        wr(REG_EVTYPE, 32'h0000_003C);
        rd_chk(REG_EVTYPE, 32'h3C, "R6 event type counter 2");
        wr(REG_SEL, 32'd1);
        rd_chk(REG_EVTYPE, 32'hA5, "R6 event type counter 1 low byte");
        for (int k = 0; k < NUM_EVT; k++) begin
            wr(REG_SEL, 32'(k));
            wr(REG_EVDATA, 32'h0);
        end

        // R4 event counting under several strobe patterns
        wr(REG_EN_SET, 32'h0000_0005);
        wr(REG_CTRL, 32'h1);
        pulse(4'b1111, 3);
        pulse(4'b0100, 2);
        wr(REG_CTRL, 32'h0);
        wr(REG_SEL, 32'd0);
        rd_chk(REG_EVDATA, 32'd3, "R4 counter 0 counts");
        wr(REG_SEL, 32'd1);
        rd_chk(REG_EVDATA, 32'd0, "R4 counter 1 disabled");
        wr(REG_SEL, 32'd2);
        rd_chk(REG_EVDATA, 32'd5, "R4 counter 2 counts");
        wr(REG_SEL, 32'd3);
        rd_chk(REG_EVDATA, 32'd0, "R4 counter 3 disabled");
        rd_chk(REG_CYCDATA, 32'd0, "R5 cycle counter not enabled");
        pulse(4'b1111, 4);
        wr(REG_SEL, 32'd0);
        rd_chk(REG_EVDATA, 32'd3, "R4 global enable off holds");

        // R7 direct cycle access, R6 no cross effect
        wr(REG_SEL, 32'd2);
        wr(REG_CYCDATA, 32'h0000_0100);
        rd_chk(REG_CYCDATA, 32'h0000_0100, "R7 cycle data direct");
        rd_chk(REG_EVDATA, 32'd5, "R6 selected counter untouched");

        // R5 cycle counting
        wr(REG_CYCDATA, 32'h0);
        wr(REG_EN_SET, 32'h8000_0000);
        wr(REG_CTRL, 32'h1);
        repeat (6) @(negedge clk);
        wr(REG_CTRL, 32'h0);
        rd_chk(REG_CYCDATA, 32'd7, "R5 cycle count");
        wr(REG_EN_CLR, 32'h8000_0000);

        // R8 event counter wrap
        wr(REG_SEL, 32'd0);
        wr(REG_EVDATA, 32'hFFFF_FFFE);
        wr(REG_CTRL, 32'h1);
        pulse(4'b0001, 1);
        rd_chk(REG_EVDATA, 32'hFFFF_FFFF, "R8 reaches all ones");
        rd_chk(REG_OVF, 32'h0, "R8 no flag before wrap");
        pulse(4'b0001, 1);
        rd_chk(REG_EVDATA, 32'h0, "R8 wraps to zero");
        rd_chk(REG_OVF, 32'h1, "R8 event flag set");
        irq_chk(1'b0, "R10 flag without irq enable");
        wr(REG_CTRL, 32'h0);

        // R8 cycle counter wrap
        wr(REG_CYCDATA, 32'hFFFF_FFFE);
        wr(REG_EN_SET, 32'h8000_0000);
        wr(REG_CTRL, 32'h1);
        @(negedge clk);
        wr(REG_CTRL, 32'h0);
        rd_chk(REG_CYCDATA, 32'h0, "R8 cycle wraps");
        rd_chk(REG_OVF, 32'h8000_0001, "R8 cycle flag at bit 31");
        wr(REG_EN_CLR, 32'h8000_0000);

        // R10 interrupt pairing
        wr(REG_IE_SET, 32'h8000_0000);
        irq_chk(1'b1, "R10 cycle flag enabled");
        wr(REG_IE_CLR, 32'h8000_0000);
        irq_chk(1'b0, "R10 enable removed");
        wr(REG_IE_SET, 32'h0000_0004);
        irq_chk(1'b0, "R10 enable without flag");
        wr(REG_IE_SET, 32'h0000_0001);
        irq_chk(1'b1, "R10 event flag enabled");

        // R9 write-one-to-clear
        wr(REG_OVF, 32'h8000_0000);
        rd_chk(REG_OVF, 32'h1, "R9 clear bit 31 only");
        irq_chk(1'b1, "R10 irq kept by bit 0");
        wr(REG_OVF, 32'h0);
        rd_chk(REG_OVF, 32'h1, "R9 zeros have no effect");
        wr(REG_OVF, 32'h1);
        rd_chk(REG_OVF, 32'h0, "R9 clear bit 0");
        irq_chk(1'b0, "R10 irq drops after clear");

        // R9 wrap and clear in one clock
        wr(REG_EVDATA, 32'hFFFF_FFFF);
        wr(REG_CTRL, 32'h1);
        evt_strobe = 4'b0001;
        wr(REG_OVF, 32'h1);
        evt_strobe = '0;
        wr(REG_CTRL, 32'h0);
        rd_chk(REG_OVF, 32'h1, "R9 wrap beats clear");
        rd_chk(REG_EVDATA, 32'h0, "R8 wrapped during clear");
        irq_chk(1'b1, "R10 irq after collision");
        wr(REG_OVF, 32'h1);

        // R11 load beats increment
        wr(REG_SEL, 32'd2);
        wr(REG_CTRL, 32'h1);
        evt_strobe = 4'b0100;
        wr(REG_EVDATA, 32'h0000_0100);
        evt_strobe = '0;
        wr(REG_CTRL, 32'h0);
        rd_chk(REG_EVDATA, 32'h0000_0100, "R11 event load wins");
        wr(REG_EN_SET, 32'h8000_0000);
        wr(REG_CTRL, 32'h1);
        wr(REG_CYCDATA, 32'h0000_0050);
        wr(REG_CTRL, 32'h0);
        rd_chk(REG_CYCDATA, 32'h0000_0051, "R11 cycle load wins then counts");

        @(negedge clk);
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
        end
    end

endmodule